// File: doc/BRIEF.md
# Float-to-Signed-Integer Converter with Ties-Away Rounding

This block converts one IEEE-754 floating-point operand to a signed two's-complement integer. The operand may be half, single or double precision, and a two-bit format code selects which. The result is 32 or 64 bits wide, chosen by a size select. Rounding is always to the nearest integer. A value exactly halfway between two integers goes to the one of larger magnitude.

Each accepted operation produces a 128-bit destination value. The integer sits in the low 32 or 64 bits. The bits above it are either kept from the previous destination value (merge mode) or cleared. Invalid and inexact conditions are reported either as status flags or as a trap request, depending on a per-condition enable.

One registered stage sits between the input and the output. A valid strobe on the input produces a valid strobe on the output one clock later. Only four format/size pairs are legal. Any other pair is reported as illegal and leaves the destination value as it was.

Top module: `fp2int_away`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low otherwise. A synchronous reset clears `out_valid` and all flag, trap and illegal outputs.
- R2: `fmt_code` 2'b11 selects half precision in `src_op[15:0]`, 2'b00 selects single in `src_op[31:0]` and 2'b01 selects double in `src_op[63:0]`. Source bits above the selected width have no effect on any output.
- R3: The legal pairs are half with either size, single with `out_wide`=1, and double with `out_wide`=0. Every other pair, including `fmt_code` 2'b10, sets `illegal`, returns `dst_old` unchanged as `result`, and raises no flag and no trap.
- R4: A finite in-range value rounds to the nearest integer, and exact halves round away from zero (2.5 gives 3, -0.5 gives -1).
- R5: With `out_wide`=0 the integer is written as 32-bit two's complement in `result[31:0]`. With `out_wide`=1 it is written as 64-bit two's complement in `result[63:0]`.
- R6: Bits of `result` above the integer are copied from `dst_old` when `merge_en`=1 and are zero when `merge_en`=0.
- R7: A NaN input of either sign gives integer 0 and the invalid condition.
- R8: An infinity, or a finite value whose rounded result is outside the signed range of the chosen size, gives the most positive value (sign 0) or the most negative value (sign 1) and the invalid condition, but not the inexact condition.
- R9: When the rounded integer differs from the input value and no invalid condition applies, the inexact condition is raised.
- R10: Zero of either sign gives integer 0 with no condition. A nonzero subnormal gives integer 0 and the inexact condition.
- R11: For each condition, `flag_invalid`/`flag_inexact` pulses with `out_valid` when its trap enable is 0. When the enable is 1, `trap_req` pulses instead and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| src_op | input | 64 | Source operand, narrower formats in low bits |
| fmt_code | input | 2 | Source format code |
| out_wide | input | 1 | Result size: 0 = 32-bit, 1 = 64-bit |
| merge_en | input | 1 | Keep upper destination bits when 1 |
| dst_old | input | DST_W | Previous destination value |
| trap_en_invalid | input | 1 | Route invalid condition to trap |
| trap_en_inexact | input | 1 | Route inexact condition to trap |
| out_valid | output | 1 | Result valid |
| result | output | DST_W | New destination value |
| flag_invalid | output | 1 | Invalid status flag pulse |
| flag_inexact | output | 1 | Inexact status flag pulse |
| illegal | output | 1 | Illegal format/size pair |
| trap_req | output | 1 | Trap request pulse |

## Verification
The bench builds the block with the default `DST_W` of 128. At that width the merge boundary is visible at both bit 32 and bit 64, above a 64-bit integer field. A behavioural model computes each rounded magnitude from the remainder and the half-unit. Directed operands sit exactly on the 2^31 and 2^63 limits, just inside and outside them, on halfway points of both signs, and on subnormals, zeros, infinities and NaNs for each format. Randomised operands then exercise every format code, size, merge and trap-enable combination.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int MANT_W   = 53;   // hidden bit plus widest fraction
    localparam int EXP_W    = 13;   // signed unbiased exponent
    localparam int SRC_W    = 64;
    localparam int INT_NARW = 32;
    localparam int INT_WIDW = 64;
    localparam int N_FMT    = 3;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_RSVD   = 2'b10,
        FMT_HALF   = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_FINITE,
        CLS_INF,
        CLS_NAN
    } cls_e;

    typedef struct packed {
        logic              sign;
        cls_e              cls;
        logic [EXP_W-1:0]  exp;    // two's complement, unbiased
        logic [MANT_W-1:0] mant;   // binary point after bit MANT_W-1
    } fp_fields_t;

    typedef struct packed {
        logic [INT_WIDW-1:0] value;
        logic                invalid;
        logic                inexact;
    } conv_t;

    // index 0 = half, 1 = single, 2 = double
    function automatic int fmt_exp_w(int idx);
        return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
    endfunction

    function automatic int fmt_frac_w(int idx);
        return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
    endfunction

    function automatic logic pair_legal(fmt_e f, logic wide);
        return (f == FMT_HALF) || (f == FMT_SINGLE && wide) || (f == FMT_DOUBLE && !wide);
    endfunction

endpackage

// File: rtl/fp_field_decode.sv
module fp_field_decode
    import fcvt_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] raw,
    output fp_fields_t     fld
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int MSH  = MANT_W - 1 - FW;

    logic [EW-1:0] ef;
    logic [FW-1:0] fr;
    logic          ef_zero, ef_ones, fr_zero;

    assign ef      = raw[EW+FW-1:FW];
    assign fr      = raw[FW-1:0];
    assign ef_zero = ~|ef;
    assign ef_ones = &ef;
    assign fr_zero = ~|fr;

    always_comb begin
        fld.sign = raw[EW+FW];
        fld.mant = MANT_W'({~ef_zero, fr}) << MSH;
        fld.exp  = ef_zero ? EXP_W'(1 - BIAS) : (EXP_W'(ef) - EXP_W'(BIAS));
        if (ef_ones)
            fld.cls = fr_zero ? CLS_INF : CLS_NAN;
        else if (ef_zero && fr_zero)
            fld.cls = CLS_ZERO;
        else
            fld.cls = CLS_FINITE;
    end
endmodule

// File: rtl/fp_round_int.sv
module fp_round_int
    import fcvt_pkg::*;
(
    input  fp_fields_t fld,
    input  logic       wide,
    output conv_t      cv
);
    localparam int GW = 3 * INT_WIDW;            // integer, fraction, alignment room
    localparam int GP = GW - MANT_W;

    logic [GW-1:0]       g, sh;
    logic [7:0]          samt;
    logic [INT_WIDW-1:0] imag, sat, neg;
    logic [INT_WIDW:0]   rmag, limit;
    logic                rb, sb, big, tiny, ovf;

    always_comb begin
        big   = $signed(fld.exp) > $signed(EXP_W'(INT_WIDW - 1));
        tiny  = $signed(fld.exp) < $signed(EXP_W'(-1));
        samt  = (big || tiny) ? 8'd0 : 8'($signed(EXP_W'(2 * INT_WIDW - 1)) - $signed(fld.exp));
        g     = {fld.mant, {GP{1'b0}}};
        sh    = g >> samt;
        imag  = sh[2*INT_WIDW-1:INT_WIDW];
        rb    = sh[INT_WIDW-1];
        sb    = |sh[INT_WIDW-2:0];
        if (tiny) begin
            imag = '0;
            rb   = 1'b0;
            sb   = |fld.mant;
        end
        // ties go away from zero: the half bit alone decides on magnitude
        rmag  = {1'b0, imag} + (INT_WIDW+1)'(rb);
        limit = wide ? ((INT_WIDW+1)'(1) << (INT_WIDW - 1)) : ((INT_WIDW+1)'(1) << (INT_NARW - 1));
        ovf   = big || (fld.sign ? (rmag > limit) : (rmag >= limit));
        sat   = fld.sign ? (~limit[INT_WIDW-1:0] + 1'b1) : (limit[INT_WIDW-1:0] - 1'b1);
        neg   = ~rmag[INT_WIDW-1:0] + 1'b1;

        cv = '0;
        unique case (fld.cls)
            CLS_NAN:  cv.invalid = 1'b1;
            CLS_INF: begin
                cv.value   = sat;
                cv.invalid = 1'b1;
            end
            CLS_ZERO: cv.value = '0;
            default: begin
                if (ovf) begin
                    cv.value   = sat;
                    cv.invalid = 1'b1;
                end else begin
                    cv.value   = fld.sign ? neg : rmag[INT_WIDW-1:0];
                    cv.inexact = rb | sb;
                end
            end
        endcase
    end
endmodule

// File: rtl/fp_result_place.sv
module fp_result_place
    import fcvt_pkg::*;
#(
    parameter int DST_W = 128
) (
    input  logic [INT_WIDW-1:0] value,
    input  logic                wide,
    input  logic                merge,
    input  logic                legal,
    input  logic [DST_W-1:0]    old,
    output logic [DST_W-1:0]    res
);
    always_comb begin
        if (!legal) begin
            res = old;
        end else begin
            res = merge ? old : '0;
            if (wide)
                res[INT_WIDW-1:0] = value;
            else
                res[INT_NARW-1:0] = value[INT_NARW-1:0];
        end
    end
endmodule

// File: rtl/fp2int_away.sv
module fp2int_away
    import fcvt_pkg::*;
#(
    parameter int DST_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] src_op,
    input  logic [1:0]       fmt_code,
    input  logic             out_wide,
    input  logic             merge_en,
    input  logic [DST_W-1:0] dst_old,
    input  logic             trap_en_invalid,
    input  logic             trap_en_inexact,
    output logic             out_valid,
    output logic [DST_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact,
    output logic             illegal,
    output logic             trap_req
);
    fp_fields_t       dec [N_FMT];
    fp_fields_t       sel;
    conv_t            cv;
    logic             legal, raise_inv, raise_inx;
    logic [DST_W-1:0] placed;
    fmt_e             fmt;

    assign fmt = fmt_e'(fmt_code);

    for (genvar i = 0; i < N_FMT; i++) begin : g_dec
        localparam int EW = fmt_exp_w(i);
        localparam int FW = fmt_frac_w(i);
        fp_field_decode #(.EW(EW), .FW(FW)) u_dec (
            .raw (src_op[EW+FW:0]),
            .fld (dec[i])
        );
    end

    always_comb begin
        unique case (fmt)
            FMT_HALF:   sel = dec[0];
            FMT_SINGLE: sel = dec[1];
            default:    sel = dec[2];
        endcase
    end

    fp_round_int u_round (
        .fld  (sel),
        .wide (out_wide),
        .cv   (cv)
    );

    assign legal = pair_legal(fmt, out_wide);

    fp_result_place #(.DST_W(DST_W)) u_place (
        .value (cv.value),
        .wide  (out_wide),
        .merge (merge_en),
        .legal (legal),
        .old   (dst_old),
        .res   (placed)
    );

    assign raise_inv = in_valid && legal && cv.invalid;
    assign raise_inx = in_valid && legal && cv.inexact;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            illegal      <= 1'b0;
            trap_req     <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            result       <= placed;
            flag_invalid <= raise_inv && !trap_en_invalid;
            flag_inexact <= raise_inx && !trap_en_inexact;
            illegal      <= in_valid && !legal;
            trap_req     <= (raise_inv && trap_en_invalid) || (raise_inx && trap_en_inexact);
        end
    end
endmodule

// File: rtl/fp2int_away_chk.sv
module fp2int_away_chk #(
    parameter int DST_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_wide,
    input logic             merge_en,
    input logic [DST_W-1:0] dst_old,
    input logic             out_valid,
    input logic [DST_W-1:0] result,
    input logic             flag_invalid,
    input logic             flag_inexact,
    input logic             illegal,
    input logic             trap_req
);
    AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid))); // R1

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!flag_invalid && !flag_inexact && !trap_req && !illegal)); // R11

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (!flag_invalid && !flag_inexact && !trap_req
                                    && result == $past(dst_old))); // R3

    AST_INV_NOT_INX: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(flag_invalid && flag_inexact)); // R8

    AST_UPPER_MERGE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(merge_en))
            |-> (result[DST_W-1:64] == $past(dst_old[DST_W-1:64]))); // R6

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && !$past(merge_en)) |-> (result[DST_W-1:64] == '0)); // R6

    AST_NARROW_PLACE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && !$past(out_wide))
            |-> (result[63:32] == ($past(merge_en) ? $past(dst_old[63:32]) : 32'd0))); // R5
endmodule

bind fp2int_away fp2int_away_chk #(.DST_W(DST_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .out_wide     (out_wide),
    .merge_en     (merge_en),
    .dst_old      (dst_old),
    .out_valid    (out_valid),
    .result       (result),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .illegal      (illegal),
    .trap_req     (trap_req)
);

// File: tb/fp2int_away_bench.sv
module fp2int_away_bench;
    localparam int DST_W = 128;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [63:0]      src_op;
    logic [1:0]       fmt_code;
    logic             out_wide, merge_en;
    logic [DST_W-1:0] dst_old;
    logic             trap_en_invalid, trap_en_inexact;
    logic             out_valid, flag_invalid, flag_inexact, illegal, trap_req;
    logic [DST_W-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    fp2int_away #(.DST_W(DST_W)) u_fp2int_away (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_op(src_op), .fmt_code(fmt_code),
        .out_wide(out_wide), .merge_en(merge_en), .dst_old(dst_old),
        .trap_en_invalid(trap_en_invalid), .trap_en_inexact(trap_en_inexact),
        .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
        .flag_inexact(flag_inexact), .illegal(illegal), .trap_req(trap_req)
    );

    // pending expectation for the next output cycle
    logic             p_v;
    logic [DST_W-1:0] p_res;
    logic             p_fi, p_fx, p_il, p_tr;
    string            p_tag;

    task automatic chk(string req, string what, logic [DST_W-1:0] act, logic [DST_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [63:0] s, input logic [1:0] f, input logic w, m,
                         input logic [DST_W-1:0] old, input logic ti, tx,
                         output logic [DST_W-1:0] r, output logic fi, fx, il, tr);
        int ew, fw, bias, e;
        logic sg, inv, inx;
        logic [63:0] ef, fr, val;
        logic [127:0] mm, q, rem, half, lim;
        il = !((f == 2'b11) || (f == 2'b00 && w) || (f == 2'b01 && !w));
        r = old; fi = 0; fx = 0; tr = 0;
        if (il) return;
        case (f)
            2'b11:   begin ew = 5;  fw = 10; end
            2'b00:   begin ew = 8;  fw = 23; end
            default: begin ew = 11; fw = 52; end
        endcase
        bias = (1 << (ew - 1)) - 1;
        sg   = s[ew+fw];
        ef   = (s >> fw) & ((64'd1 << ew) - 1);
        fr   = s & ((64'd1 << fw) - 1);
        lim  = w ? (128'd1 << 63) : (128'd1 << 31);
        inv = 0; inx = 0; val = 0; q = 0;
        if (ef == (64'd1 << ew) - 1) begin
            inv = 1;
            if (fr == 0) val = sg ? (~lim[63:0] + 64'd1) : (lim[63:0] - 64'd1);
        end else begin
            e  = (ef == 0) ? 1 - bias : int'(ef) - bias;
            mm = ((ef != 0) ? (128'd1 << 52) : 128'd0) | (128'(fr) << (52 - fw));
            if (e < -1) begin
                q = 0; inx = (mm != 0);
            end else if (e >= 64) begin
                q = 128'd1 << 80;
            end else if (e >= 52) begin
                q = mm << (e - 52);
            end else begin
                q    = mm >> (52 - e);
                rem  = mm - (q << (52 - e));
                half = 128'd1 << (51 - e);
                inx  = (rem != 0);
                if (rem >= half) q = q + 1;
            end
            if (sg ? (q > lim) : (q >= lim)) begin
                inv = 1; inx = 0;
                val = sg ? (~lim[63:0] + 64'd1) : (lim[63:0] - 64'd1);
            end else begin
                val = sg ? (~q[63:0] + 64'd1) : q[63:0];
            end
        end
        if (!m) r = '0;
        if (w) r[63:0] = val; else r[31:0] = val[31:0];
        fi = inv && !ti;
        fx = inx && !tx;
        tr = (inv && ti) || (inx && tx);
    endtask

    task automatic step(logic v, logic [63:0] s, logic [1:0] f, logic w, m,
                        logic [DST_W-1:0] old, logic ti, tx, string tag);
        @(negedge clk);
        chk("R1", "out_valid", DST_W'(out_valid), DST_W'(p_v));
        if (p_v) begin
            chk("R3", "illegal", DST_W'(illegal), DST_W'(p_il));
            chk(p_tag, "result", result, p_res);
            chk(p_tag, "flag_invalid", DST_W'(flag_invalid), DST_W'(p_fi));
            chk(p_tag, "flag_inexact", DST_W'(flag_inexact), DST_W'(p_fx));
            chk("R11", "trap_req", DST_W'(trap_req), DST_W'(p_tr));
        end
        in_valid = v; src_op = s; fmt_code = f; out_wide = w; merge_en = m;
        dst_old = old; trap_en_invalid = ti; trap_en_inexact = tx;
        p_v = v; p_tag = tag;
        model(s, f, w, m, old, ti, tx, p_res, p_fi, p_fx, p_il, p_tr);
    endtask

    localparam logic [DST_W-1:0] OLD_A = 128'hA5A5_5A5A_1234_5678_9ABC_DEF0_0F0F_F0F0;
    localparam logic [DST_W-1:0] OLD_B = 128'hFFFF_0000_FFFF_0000_CCCC_3333_7777_8888;

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; src_op = 0; fmt_code = 0; out_wide = 0; merge_en = 0;
        dst_old = 0; trap_en_invalid = 0; trap_en_inexact = 0; p_v = 0; p_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset out_valid", DST_W'(out_valid), '0);
        chk("R1", "reset flags", DST_W'({flag_invalid, flag_inexact, illegal, trap_req}), '0);
        rst = 0;

        // ties away and plain rounding, double to 32
        step(1, 64'h4004000000000000, 2'b01, 0, 0, OLD_A, 0, 0, "R4");   //  2.5 -> 3
        step(1, 64'hC004000000000000, 2'b01, 0, 1, OLD_A, 0, 0, "R4");   // -2.5 -> -3
        step(1, 64'h3FE0000000000000, 2'b01, 0, 0, OLD_B, 0, 0, "R4");   //  0.5 -> 1
        step(1, 64'hBFE0000000000000, 2'b01, 0, 1, OLD_B, 0, 0, "R4");   // -0.5 -> -1
        step(0, 64'h0, 2'b01, 0, 0, OLD_A, 0, 0, "R1");
        // 32-bit range edges
        step(1, 64'h41E0000000000000, 2'b01, 0, 0, OLD_A, 0, 0, "R8");   //  2^31 saturates
        step(1, 64'hC1E0000000000000, 2'b01, 0, 1, OLD_A, 0, 0, "R5");   // -2^31 exact
        step(1, 64'hC1E0000000100000, 2'b01, 0, 0, OLD_A, 0, 0, "R8");   // -2^31-0.5 -> overflow
        step(1, 64'h41DFFFFFFFE00000, 2'b01, 0, 0, OLD_A, 0, 0, "R8");   // 2^31-0.5 -> overflow
        // half with junk above bit 15
        step(1, 64'hDEADBEEFCAFE3E00, 2'b11, 0, 1, OLD_B, 0, 0, "R2");   // 1.5 -> 2
        step(1, 64'h123456789ABCB800, 2'b11, 1, 0, OLD_B, 0, 0, "R2");   // -0.5 -> -1
        step(1, 64'h0000000000007BFF, 2'b11, 0, 1, OLD_A, 0, 0, "R5");   // 65504
        step(1, 64'h0000000000000001, 2'b11, 1, 0, OLD_A, 0, 0, "R10");  // subnormal
        step(1, 64'h0000000000008000, 2'b11, 0, 0, OLD_A, 0, 0, "R10");  // -0
        step(1, 64'h00000000000037FF, 2'b11, 1, 1, OLD_A, 0, 0, "R9");   // just under half
        step(1, 64'h0000000000007E00, 2'b11, 0, 1, OLD_A, 0, 0, "R7");   // NaN
        step(1, 64'h000000000000FC00, 2'b11, 1, 0, OLD_A, 0, 0, "R8");   // -inf
        // single to 64
        step(1, 64'h000000005E800000, 2'b00, 1, 0, OLD_B, 0, 0, "R5");   // 2^62
        step(1, 64'h000000005F000000, 2'b00, 1, 1, OLD_B, 0, 0, "R8");   // 2^63 saturates
        step(1, 64'h00000000DF000000, 2'b00, 1, 0, OLD_B, 0, 0, "R5");   // -2^63 exact
        step(1, 64'h0000000040600000, 2'b00, 1, 1, OLD_B, 0, 0, "R4");   // 3.5 -> 4
        step(1, 64'h00000000C0600000, 2'b00, 1, 0, OLD_B, 0, 0, "R4");   // -3.5 -> -4
        step(1, 64'h00000000FFC00000, 2'b00, 1, 1, OLD_B, 0, 0, "R7");   // NaN
        // double NaN/inf/subnormal
        step(1, 64'h7FF8000000000000, 2'b01, 0, 0, OLD_A, 0, 0, "R7");
        step(1, 64'h7FF0000000000000, 2'b01, 0, 1, OLD_A, 0, 0, "R8");
        step(1, 64'h8000000000000001, 2'b01, 0, 0, OLD_A, 0, 0, "R10");
        // merge behaviour
        step(1, 64'h4004000000000000, 2'b01, 0, 1, OLD_B, 0, 0, "R6");
        step(1, 64'h0000000000003E00, 2'b11, 1, 1, OLD_B, 0, 0, "R6");
        step(1, 64'h0000000000003E00, 2'b11, 1, 0, OLD_B, 0, 0, "R6");
        // illegal pairs
        step(1, 64'h0000000040600000, 2'b00, 0, 0, OLD_A, 1, 1, "R3");
        step(1, 64'h4004000000000000, 2'b01, 1, 0, OLD_B, 1, 1, "R3");
        step(1, 64'h0000000000003E00, 2'b10, 0, 0, OLD_A, 0, 0, "R3");
        step(1, 64'h7FF8000000000000, 2'b10, 1, 1, OLD_B, 1, 0, "R3");
        // trap routing
        step(1, 64'h7FF8000000000000, 2'b01, 0, 0, OLD_A, 1, 0, "R11");
        step(1, 64'h3FE0000000000000, 2'b01, 0, 0, OLD_A, 0, 1, "R11");
        step(1, 64'h3FE0000000000000, 2'b01, 0, 0, OLD_A, 1, 0, "R11");
        step(1, 64'h000000005F000000, 2'b00, 1, 0, OLD_A, 0, 1, "R11");
        step(0, 64'h0, 2'b00, 0, 0, OLD_A, 0, 0, "R1");

        // randomised operands across all codes, sizes and enables
        for (int i = 0; i < 400; i++) begin
            logic [63:0] s;
            logic [3:0]  ctl;
            s = {$urandom, $urandom};
            if (i % 3 == 0) s[62:52] = 11'(1023 + ($urandom % 70) - 8);
            if (i % 5 == 1) s[30:23] = 8'(127 + ($urandom % 70) - 8);
            ctl = 4'($urandom);
            step((i % 7) != 6, s, 2'($urandom), ctl[0], ctl[1],
                 {$urandom, $urandom, $urandom, $urandom}, ctl[2], ctl[3], "R9");
        end
        step(0, 64'h0, 2'b00, 0, 0, OLD_A, 0, 0, "R1");
        step(0, 64'h0, 2'b00, 0, 0, OLD_A, 0, 0, "R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule